// File: doc/BRIEF.md
# EEPROM Page Update Buffer

This block gathers single-byte writes aimed at one page of a small emulated EEPROM. When software starts the operation, it writes all of them back in one commit. A commit replaces whole bytes, so any bit can go from 0 to 1 or from 1 to 0. Bytes of the page that were never entered keep their old value. Entries may arrive in any offset order. Writing the same offset again replaces the earlier data. The first accepted entry fixes the page for the batch. A later entry that names another page is dropped and raises a sticky error flag.

A three-bit control word sets the operation: a start bit (bit 2), a page-update select (bit 1) and a chip-erase select (bit 0). Chip erase fills both sectors with FFh and wins over page update when both are selected. No operation launches while an external flash erase suspend is asserted. While the operation runs, busy stays high for a fixed number of cycles. The store changes on the edge where busy falls. At that point the start bit and the select of the operation that ran clear themselves, and the entry mask empties. The store is a behavioural byte array with an asynchronous read port.

Top module: `epu_page_update`

## Requirements
- R1: After reset every store byte reads FFh, and `busy_o`, `err_o` and `ctrl_o` are all 0.
- R2: After 1 to 16 entries to one page, in any offset order, a control write with start (bit 2) and page select (bit 1) writes each entered byte at its address. The page is address bits [6:4] and the offset is bits [3:0].
- R3: A page commit replaces the whole byte, so bits change in both directions (for example A5h becomes 5Ah).
- R4: Page bytes that were not entered keep their old contents. A repeated entry to the same offset keeps only the last data.
- R5: An entry whose page differs from the batch's first entry is dropped, and `err_o` is set and stays set until reset.
- R6: Start with chip select (bit 0) sets every byte of both sectors to FFh. Chip erase takes priority over page update, and completing it clears only the chip select.
- R7: `busy_o` rises on the edge that takes the launching control write. It stays high for exactly WRITE_CYCLES cycles, and `ctrl_o` bit 2 reads 1 during that time. The store changes only on the edge where `busy_o` falls.
- R8: While `busy_o` is high, entry writes and control writes have no effect. This includes a write that clears the start bit.
- R9: A start issued while `erase_susp_i` is high launches nothing and leaves the store unchanged. The select bits still take the written value, and the entries are kept for a later start.
- R10: When an operation completes, the start bit and the select of the operation that ran clear, and the entry mask empties.
- R11: A start with no select set, or with only page select set and no entries held, launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry write strobe |
| wr_addr_i | input | 7 | Entry byte address (page in [6:4], offset in [3:0]) |
| wr_data_i | input | 8 | Entry data byte |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_data_i | input | 3 | Control word: bit 2 start, bit 1 page select, bit 0 chip select |
| erase_susp_i | input | 1 | External flash erase suspend, blocks launch |
| rd_addr_i | input | 7 | Store read address |
| rd_data_o | output | 8 | Store read data (combinational) |
| busy_o | output | 1 | Operation in progress |
| ctrl_o | output | 3 | Control word readback, same bit layout |
| err_o | output | 1 | Sticky page-mismatch flag |

## Verification
The hardest case to reach is a control write that lands while an operation is running. A one-cycle gap has to be hit on purpose, so the stimulus issues a launch and, on the very next cycle, drives a fresh entry together with a control word that clears the start bit. The bench then checks that the commit still finishes on time and that the late entry never reaches the store. The suspend case also needs its own sequence: entries are loaded, a start is refused under suspend, and then a second start without suspend must commit the entries that were kept.

// File: rtl/epu_pkg.sv
package epu_pkg;
  typedef struct packed {
    logic start;
    logic page;
    logic chip;
  } epu_ctrl_t;
endpackage

// File: rtl/epu_entry_buf.sv
module epu_entry_buf #(
  parameter int ADDR_W = 7,
  parameter int OFS_W  = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [7:0]                        data_i,
  input  logic                              lock_i,
  input  logic                              flush_i,
  output logic [(1<<OFS_W)-1:0]             mask_o,
  output logic [(1<<OFS_W)-1:0][7:0]        data_o,
  output logic [ADDR_W-OFS_W-1:0]           page_o,
  output logic                              err_o
);
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PG_W       = ADDR_W - OFS_W;

  logic [PAGE_BYTES-1:0]      mask_q;
  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [PG_W-1:0]            page_q;
  logic                       err_q;
  logic [PG_W-1:0]            in_page;
  logic [OFS_W-1:0]           in_ofs;
  logic                       accept;

  assign in_page = addr_i[ADDR_W-1:OFS_W];
  assign in_ofs  = addr_i[OFS_W-1:0];
  assign accept  = (mask_q == '0) || (in_page == page_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      data_q <= '0;
      page_q <= '0;
      err_q  <= 1'b0;
    end else if (flush_i) begin
      mask_q <= '0;
    end else if (wr_en_i && !lock_i) begin
      if (accept) begin
        if (mask_q == '0) page_q <= in_page;
        mask_q[in_ofs] <= 1'b1;
        data_q[in_ofs] <= data_i;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign mask_o = mask_q;
  assign data_o = data_q;
  assign page_o = page_q;
  assign err_o  = err_q;
endmodule

// File: rtl/epu_seq.sv
module epu_seq
  import epu_pkg::*;
#(
  parameter int WRITE_CYCLES = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ctrl_wr_i,
  input  epu_ctrl_t ctrl_i,
  input  logic      susp_i,
  input  logic      have_entries_i,
  output epu_ctrl_t ctrl_o,
  output logic      busy_o,
  output logic      erase_all_o,
  output logic      commit_page_o
);
  localparam int CNT_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;

  logic             start_q, page_q, chip_q, op_chip_q;
  logic [CNT_W-1:0] cnt_q;
  logic             launch, done;

  assign launch = ctrl_wr_i && ctrl_i.start && !start_q && !susp_i &&
                  (ctrl_i.chip || (ctrl_i.page && have_entries_i));
  assign done   = start_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= 1'b0;
      page_q    <= 1'b0;
      chip_q    <= 1'b0;
      op_chip_q <= 1'b0;
      cnt_q     <= '0;
    end else if (start_q) begin
      if (done) begin
        start_q <= 1'b0;
        if (op_chip_q) chip_q <= 1'b0;
        else           page_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (ctrl_wr_i) begin
      page_q    <= ctrl_i.page;
      chip_q    <= ctrl_i.chip;
      start_q   <= launch;
      op_chip_q <= ctrl_i.chip;
      cnt_q     <= CNT_W'(WRITE_CYCLES - 1);
    end
  end

  assign ctrl_o        = '{start: start_q, page: page_q, chip: chip_q};
  assign busy_o        = start_q;
  assign erase_all_o   = done && op_chip_q;
  assign commit_page_o = done && !op_chip_q;
endmodule

// File: rtl/epu_store.sv
module epu_store #(
  parameter int ADDR_W = 7,
  parameter int OFS_W  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          erase_all_i,
  input  logic                          commit_i,
  input  logic [ADDR_W-OFS_W-1:0]       page_i,
  input  logic [(1<<OFS_W)-1:0]         mask_i,
  input  logic [(1<<OFS_W)-1:0][7:0]    data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [7:0]                    rd_data_o
);
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << OFS_W;

  logic [DEPTH-1:0][7:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= {DEPTH{8'hFF}};
    end else if (erase_all_i) begin
      mem_q <= {DEPTH{8'hFF}};
    end else if (commit_i) begin
      for (int o = 0; o < PAGE_BYTES; o++) begin
        if (mask_i[o]) mem_q[{page_i, OFS_W'(o)}] <= data_i[o];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/epu_page_update.sv
module epu_page_update
  import epu_pkg::*;
#(
  parameter int SECTOR_BYTES = 64,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [$clog2(2*SECTOR_BYTES)-1:0] wr_addr_i,
  input  logic [7:0]                        wr_data_i,
  input  logic                              ctrl_wr_i,
  input  logic [2:0]                        ctrl_data_i,
  input  logic                              erase_susp_i,
  input  logic [$clog2(2*SECTOR_BYTES)-1:0] rd_addr_i,
  output logic [7:0]                        rd_data_o,
  output logic                              busy_o,
  output logic [2:0]                        ctrl_o,
  output logic                              err_o
);
  localparam int ADDR_W = $clog2(2 * SECTOR_BYTES);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PG_W   = ADDR_W - OFS_W;

  logic [PAGE_BYTES-1:0]      mask;
  logic [PAGE_BYTES-1:0][7:0] pdata;
  logic [PG_W-1:0]            page;
  logic                       busy, erase_all, commit_page;
  epu_ctrl_t                  ctrl_in, ctrl_st;

  assign ctrl_in = epu_ctrl_t'(ctrl_data_i);

  epu_entry_buf #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .lock_i  (busy),
    .flush_i (erase_all || commit_page),
    .mask_o  (mask),
    .data_o  (pdata),
    .page_o  (page),
    .err_o   (err_o)
  );

  epu_seq #(.WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_wr_i      (ctrl_wr_i),
    .ctrl_i         (ctrl_in),
    .susp_i         (erase_susp_i),
    .have_entries_i (|mask),
    .ctrl_o         (ctrl_st),
    .busy_o         (busy),
    .erase_all_o    (erase_all),
    .commit_page_o  (commit_page)
  );

  epu_store #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_all_i (erase_all),
    .commit_i    (commit_page),
    .page_i      (page),
    .mask_i      (mask),
    .data_i      (pdata),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
  );

  assign busy_o = busy;
  assign ctrl_o = ctrl_st;
endmodule

// File: rtl/epu_checker.sv
module epu_checker #(
  parameter int ADDR_W       = 7,
  parameter int WRITE_CYCLES = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              erase_susp_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [7:0]        rd_data_o,
  input logic              busy_o,
  input logic [2:0]        ctrl_o,
  input logic              err_o
);
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  AST_BUSY_SHOWS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ctrl_o[2]); // R7
  AST_BUSY_NOT_TOO_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (busy_run < WRITE_CYCLES)); // R7
  AST_BUSY_EXACT_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_run == WRITE_CYCLES)); // R7
  AST_STORE_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R5
  AST_SUSP_NO_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && erase_susp_i) |=> !busy_o); // R9
  AST_SELECTS_HELD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ctrl_o[1:0])); // R8
endmodule

bind epu_page_update epu_checker #(
  .ADDR_W       ($clog2(2 * SECTOR_BYTES)),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_epu_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .erase_susp_i (erase_susp_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .busy_o       (busy_o),
  .ctrl_o       (ctrl_o),
  .err_o        (err_o)
);

// File: tb/tb_epu_page_update.sv
`timescale 1ns/100ps
module tb_epu_page_update;
  localparam int WC    = 8;
  localparam int DEPTH = 128;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 0, ctrl_wr = 0, susp = 0;
  logic [6:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] ctrl_d = 0;
  logic [7:0] rd_data;
  logic       busy, err;
  logic [2:0] ctrl_q;

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model state
  int mem_m [DEPTH];
  int buf_m [16];
  int mask_m, page_m, cnt_m;
  bit err_m, start_m, psel_m, csel_m, opchip_m;

  always #2 clk = ~clk;

  epu_page_update #(.SECTOR_BYTES(64), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_d),
    .erase_susp_i(susp), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .busy_o(busy), .ctrl_o(ctrl_q), .err_o(err)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
    for (int i = 0; i < 16; i++) buf_m[i] = 0;
    mask_m = 0; page_m = 0; cnt_m = 0;
    err_m = 0; start_m = 0; psel_m = 0; csel_m = 0; opchip_m = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit launch;
      launch = ctrl_wr && ctrl_d[2] && !start_m && !susp &&
               (ctrl_d[0] || (ctrl_d[1] && mask_m != 0));
      if (wr_en && !start_m) begin
        int pg, of;
        pg = wr_addr / 16; of = wr_addr % 16;
        if (mask_m == 0 || pg == page_m) begin
          if (mask_m == 0) page_m = pg;
          buf_m[of] = wr_data;
          mask_m = mask_m | (1 << of);
        end else err_m = 1;
      end
      if (start_m) begin
        if (cnt_m == 0) begin
          if (opchip_m) begin
            for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'hFF;
            csel_m = 0;
          end else begin
            for (int o = 0; o < 16; o++)
              if (mask_m & (1 << o)) mem_m[page_m*16 + o] = buf_m[o];
            psel_m = 0;
          end
          mask_m = 0;
          start_m = 0;
        end else cnt_m--;
      end else if (ctrl_wr) begin
        psel_m = ctrl_d[1]; csel_m = ctrl_d[0];
        if (launch) begin
          start_m = 1; cnt_m = WC - 1; opchip_m = ctrl_d[0];
        end
      end
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy, start_m, "R7 busy");
      chk(ctrl_q, {start_m, psel_m, csel_m}, "R10 ctrl");
      chk(err, err_m, "R5 err");
      chk(rd_data, mem_m[rd_addr], "R2 rd_data");
    end
  end

  task automatic entry(input int a, input int d);
    @(negedge clk); #1 wr_en = 1; wr_addr = 7'(a); wr_data = 8'(d);
    @(negedge clk); #1 wr_en = 0;
  endtask

  task automatic run_op(input logic [2:0] v, output int n);
    @(negedge clk); #1 ctrl_wr = 1; ctrl_d = v;
    @(negedge clk); #1 ctrl_wr = 0;
    n = 0;
    while (busy) begin n++; @(negedge clk); #1; end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk); #1 rd_addr = 7'(a); #0.5;
    chk(rd_data, exp, tag);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    #9 rst_n = 1;
    // R1 reset state
    @(negedge clk); #1;
    chk(busy, 0, "R1 busy");
    chk(ctrl_q, 0, "R1 ctrl");
    chk(err, 0, "R1 err");
    rd(0, 8'hFF, "R1 mem0");
    rd(127, 8'hFF, "R1 mem127");

    // R2 out-of-order entries on page 2
    entry(8'h25, 8'hA5); entry(8'h20, 8'h3C); entry(8'h2F, 8'h00); entry(8'h23, 8'h7E);
    run_op(3'b110, n);
    chk(n, WC, "R7 busy length");
    chk(ctrl_q, 0, "R10 selects cleared");
    rd(8'h25, 8'hA5, "R2 byte5");
    rd(8'h2F, 8'h00, "R2 byte15");
    rd(8'h21, 8'hFF, "R4 unentered");

    // R3 bits both ways, R4 repeated offset
    entry(8'h25, 8'h5A); entry(8'h20, 8'h11); entry(8'h20, 8'hC3);
    run_op(3'b110, n);
    rd(8'h25, 8'h5A, "R3 flip");
    rd(8'h20, 8'hC3, "R4 last wins");
    rd(8'h23, 8'h7E, "R4 kept");

    // R5 page mismatch
    entry(8'h30, 8'h12); entry(8'h10, 8'h34);
    @(negedge clk); #1 chk(err, 1, "R5 err set");
    run_op(3'b110, n);
    rd(8'h30, 8'h12, "R5 first page written");
    rd(8'h10, 8'hFF, "R5 dropped");
    chk(err, 1, "R5 sticky");

    // R9 suspend blocks launch
    entry(8'h40, 8'h99);
    susp = 1;
    run_op(3'b110, n);
    chk(n, 0, "R9 no launch");
    chk(ctrl_q, 3'b010, "R9 select kept");
    rd(8'h40, 8'hFF, "R9 store untouched");
    #1 susp = 0;
    run_op(3'b110, n);
    chk(n, WC, "R9 later launch");
    rd(8'h40, 8'h99, "R9 entries retained");

    // R8 writes during busy ignored
    entry(8'h50, 8'h77);
    @(negedge clk); #1 ctrl_wr = 1; ctrl_d = 3'b110;
    @(negedge clk); #1 ctrl_wr = 1; ctrl_d = 3'b000; wr_en = 1; wr_addr = 7'h51; wr_data = 8'h88;
    chk(busy, 1, "R8 busy");
    @(negedge clk); #1 ctrl_wr = 0; wr_en = 0;
    chk(ctrl_q, 3'b110, "R8 clear ignored");
    while (busy) begin @(negedge clk); #1; end
    chk(ctrl_q, 0, "R10 done");
    rd(8'h50, 8'h77, "R8 commit done");
    rd(8'h51, 8'hFF, "R8 late entry ignored");

    // R11 no launch without target
    run_op(3'b100, n);
    chk(n, 0, "R11 no select");
    run_op(3'b110, n);
    chk(n, 0, "R11 empty mask");
    chk(ctrl_q, 3'b010, "R11 select only");

    // R6 chip erase priority, R10 mask flushed
    entry(8'h60, 8'h01);
    run_op(3'b111, n);
    chk(n, WC, "R6 busy length");
    chk(ctrl_q, 3'b010, "R6 only chip cleared");
    rd(8'h25, 8'hFF, "R6 erased");
    rd(8'h60, 8'hFF, "R6 entry not written");
    rd(8'h7F, 8'hFF, "R6 last byte");
    run_op(3'b110, n);
    chk(n, 0, "R10 mask empty");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule